// File: doc/BRIEF.md
# Ethernet Receive Ping-Pong Buffer with Destination Filter

This block is the receive half of a small Ethernet MAC. Frame bytes arrive one per valid cycle with a flag on the final byte. The first six bytes are judged against a programmed station address. A frame is kept if it matches that address exactly, or if bit 7 of its first byte is set (group address). A kept frame is packed into 32-bit words and written into one of two receive buffers. Software then reads the frame over a word-addressed port and hands the buffer back by clearing its full flag.

Each buffer has its own control word with a full flag and an interrupt enable. A buffer belongs to the hardware until software releases it. When alternation is switched on, the hardware moves to the other buffer after each kept frame. When alternation is off, it always returns to buffer 0. A frame that arrives while the selected buffer is still full is thrown away and reported on a one-cycle lost pulse. A frame that fails the filter, or that ends before its sixth byte, leaves no trace in the buffers or their status.

The bus window is word addressed. The top address bit selects the buffer, and the last word of each buffer is its control word. With the receive window placed at byte offset 0x1000, buffer 0 therefore spans 0x1000 to 0x17FC and buffer 1 spans 0x1800 to 0x1FFC.

Top module: `eth_rx_pingpong`

## Requirements
- R1: After a synchronous active-low reset, buffer 0 is selected, both control words read 0, `rx_ready` is 1, and `irq` and `rx_lost` are 0.
- R2: A kept frame is stored from data word 0 of its buffer upward. The byte received k-th goes to word k/4 at bits [8*(k%4)+7 : 8*(k%4)]. Byte lanes of the last partial word that the frame does not reach read as zero.
- R3: A frame is kept when bit 7 of its first byte is 1, or when for every k in 0..5 its k-th byte equals `station_addr[8k+7:8k]`. A frame that is not kept changes no buffer word and no control word, and causes no `irq` or `rx_lost` pulse.
- R4: A frame whose last byte comes before its sixth byte is discarded with no effect on buffers, status, `irq` or `rx_lost`.
- R5: Each buffer holds 4*(BUF_WORDS-1) data bytes. Bytes beyond that are not stored, but the frame is still completed as kept.
- R6: After the last byte of a kept frame, the full flag (control bit 0) of its buffer is set. In the cycle after that last byte, `irq` pulses high for exactly one cycle if the buffer's enable (control bit 3) and `irq_global_en` are both 1. Otherwise `irq` stays 0.
- R7: `rx_ready` equals the inverse of the selected buffer's full flag. A frame whose first byte arrives while that flag is set is not stored. It gives one `rx_lost` pulse in the cycle after its first byte, and it leaves the selection unchanged.
- R8: After each kept frame the selection toggles when `pingpong_en` is 1, and becomes buffer 0 when it is 0. The selection never changes while a frame is in progress.
- R9: A write to a control word loads the enable from bit 3. It clears the full flag when bit 0 is 0 and leaves the flag unchanged when bit 0 is 1. If such a write hits the buffer that a frame completes into in the same cycle, the flag ends up set, and the interrupt decision uses the enable held before the write.
- R10: `bus_addr[ADDR_W-1]` selects the buffer and the low bits select the word. Word BUF_WORDS-1 is the control word, and the other words are data. `bus_rdata` shows the addressed word one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A frame byte is present this cycle |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| rx_ready | output | 1 | Selected buffer is free to take a frame |
| station_addr | input | 48 | Station address, byte k in bits [8k+7:8k] |
| pingpong_en | input | 1 | Alternate buffers after each kept frame |
| irq_global_en | input | 1 | Global gate on the receive interrupt |
| bus_addr | input | ADDR_W | Word address inside the receive window |
| bus_we | input | 1 | Write strobe (control words only) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after address |
| irq | output | 1 | One-cycle receive interrupt pulse |
| rx_lost | output | 1 | One-cycle pulse for a frame dropped on a full buffer |

## Verification
Two things can happen in the same cycle: the hardware completes a frame into the selected buffer, and software writes that buffer's control word to release it and turn its interrupt off. The bench provokes this by raising the control write on the same edge as the frame's last byte. It then expects the full flag to read back set, the enable to read back cleared, and exactly one interrupt pulse taken from the enable held before the write. Around this case the bench sweeps every frame length through the buffer boundary, a mismatch in each of the six address positions, group addresses, drops on a full buffer, both alternation modes and both interrupt gates. Every result is compared with a model of the buffer contents and status kept in the bench.

// File: rtl/eth_rx_pkg.sv
// Shared definitions for the receive ping-pong buffer.
// Assumes: control word layout is fixed by software (full flag, interrupt enable).
package eth_rx_pkg;

    localparam int CTRL_FULL_BIT = 0;
    localparam int CTRL_IEN_BIT  = 3;
    localparam int ADDR_BYTES    = 6;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_RECV = 2'd1,
        FR_SKIP = 2'd2
    } frame_state_e;

endpackage

// File: rtl/eth_rx_addr_filter.sv
// Destination address filter.
// Tracks whether the first six bytes of a frame equal the station address, and
// remembers the group bit of byte 0. The accept output is meaningful only in
// the cycle that presents byte index 5.
// Assumes: byte_en is raised once per byte with idx counting 0..5 in order.
module eth_rx_addr_filter (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_en,
    input  logic [2:0]  idx,
    input  logic [7:0]  byte_in,
    input  logic [47:0] station_addr,
    output logic        accept
);

    logic [7:0] sa_byte;
    logic       match_q;
    logic       group_q;

    // Pick the station byte that lines up with the current frame byte.
    always_comb begin
        case (idx)
            3'd0:    sa_byte = station_addr[7:0];
            3'd1:    sa_byte = station_addr[15:8];
            3'd2:    sa_byte = station_addr[23:16];
            3'd3:    sa_byte = station_addr[31:24];
            3'd4:    sa_byte = station_addr[39:32];
            3'd5:    sa_byte = station_addr[47:40];
            default: sa_byte = 8'h00;
        endcase
    end

    // Accumulate the running match and capture the group bit at byte 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= 1'b0;
            group_q <= 1'b0;
        end else if (byte_en) begin
            if (idx == 3'd0) begin
                match_q <= (byte_in == sa_byte);
                group_q <= byte_in[7];
            end else begin
                match_q <= match_q && (byte_in == sa_byte);
            end
        end
    end

    // Final verdict including the sixth byte itself.
    always_comb accept = group_q || (match_q && (byte_in == sa_byte));

endmodule

// File: rtl/eth_rx_frame.sv
// Frame sequencer and byte packer.
// Decides at the first byte whether the frame is dropped on a full buffer,
// packs bytes into little-endian words and holds word 0 back until the filter
// verdict at byte 5. Completed words go to an even and an odd bank so that
// word 0 and word 1 can both be written in the verdict cycle.
// Assumes: BUF_WORDS is a power of two and at least 4; sel only changes on commit.
module eth_rx_frame
    import eth_rx_pkg::*;
#(
    parameter int BUF_WORDS = 512
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rx_valid,
    input  logic [7:0]                  rx_data,
    input  logic                        rx_last,
    input  logic [47:0]                 station_addr,
    input  logic                        sel,
    input  logic                        sel_full,
    output logic [1:0]                  wr_en,
    output logic [1:0][$clog2(BUF_WORDS)-1:0] wr_row,
    output logic [1:0][31:0]            wr_data,
    output logic                        commit,
    output logic                        lost,
    output logic                        busy
);

    localparam int WORD_W     = $clog2(BUF_WORDS);
    localparam int DATA_BYTES = 4 * (BUF_WORDS - 1);
    localparam int CNT_W      = $clog2(DATA_BYTES + 1);
    localparam logic [CNT_W-1:0] IDX_STAGE  = CNT_W'(3);
    localparam logic [CNT_W-1:0] IDX_DECIDE = CNT_W'(5);
    localparam logic [CNT_W-1:0] IDX_FEND   = CNT_W'(ADDR_BYTES);
    localparam logic [CNT_W-1:0] IDX_LIMIT  = CNT_W'(DATA_BYTES);

    frame_state_e      state;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  idx;
    logic [1:0]        lane;
    logic [WORD_W-1:0] word;
    logic [31:0]       acc;
    logic [31:0]       acc_next;
    logic [31:0]       stage0;
    logic              take;
    logic              decide;
    logic              accept;
    logic              passed;
    logic              w0_wr;
    logic              wn_wr;
    logic              lost_q;

    eth_rx_addr_filter u_filter (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_en      (take && (idx < IDX_FEND)),
        .idx          (idx[2:0]),
        .byte_in      (rx_data),
        .station_addr (station_addr),
        .accept       (accept)
    );

    // Byte position, packing and write decisions for the byte on the input.
    always_comb begin
        idx      = (state == FR_IDLE) ? '0 : cnt;
        lane     = idx[1:0];
        word     = idx[CNT_W-1:2];
        take     = rx_valid && (((state == FR_IDLE) && !sel_full) || (state == FR_RECV));
        acc_next = (lane == 2'd0) ? {24'h0, rx_data} : acc;
        acc_next[{lane, 3'b000} +: 8] = rx_data;
        decide   = (idx == IDX_DECIDE);
        passed   = (idx > IDX_DECIDE) || (decide && accept);
        w0_wr    = take && decide && accept;
        wn_wr    = take && passed && (idx < IDX_LIMIT) && (word != '0) &&
                   ((lane == 2'd3) || rx_last);
        commit   = take && rx_last && passed;
    end

    // Route the held word 0 and the current word to their banks.
    always_comb begin
        wr_en[0]   = w0_wr || (wn_wr && !word[0]);
        wr_en[1]   = wn_wr && word[0];
        wr_row[0]  = w0_wr ? {sel, {(WORD_W-1){1'b0}}} : {sel, word[WORD_W-1:1]};
        wr_row[1]  = {sel, word[WORD_W-1:1]};
        wr_data[0] = w0_wr ? stage0 : acc_next;
        wr_data[1] = acc_next;
    end

    // Frame state, byte counter (saturating at capacity) and word staging.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= FR_IDLE;
            cnt    <= '0;
            acc    <= '0;
            stage0 <= '0;
            lost_q <= 1'b0;
        end else begin
            lost_q <= rx_valid && (state == FR_IDLE) && sel_full;
            if (take) begin
                acc <= acc_next;
                if (idx == IDX_STAGE) stage0 <= acc_next;
            end
            if (rx_valid) begin
                case (state)
                    FR_IDLE: begin
                        if (rx_last)       state <= FR_IDLE;
                        else if (sel_full) state <= FR_SKIP;
                        else begin
                            state <= FR_RECV;
                            cnt   <= CNT_W'(1);
                        end
                    end
                    FR_RECV: begin
                        if (rx_last) begin
                            state <= FR_IDLE;
                            cnt   <= '0;
                        end else if (decide && !accept) begin
                            state <= FR_SKIP;
                            cnt   <= '0;
                        end else if (cnt != IDX_LIMIT) begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    default: begin
                        if (rx_last) state <= FR_IDLE;
                    end
                endcase
            end
        end
    end

    always_comb lost = lost_q;
    always_comb busy = (state != FR_IDLE);

    // A frame is only completed into a buffer that was free at its start (R7).
    assert_commit_to_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !sel_full);

    // The lost pulse never coincides with storing bytes (R7).
    assert_lost_stores_nothing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lost |-> (state != FR_RECV) || (cnt == CNT_W'(1)));

endmodule

// File: rtl/eth_rx_bank_store.sv
// Two-bank frame storage, even words in bank 0 and odd words in bank 1.
// Each bank has one write port and one registered read port; the read bank
// choice is registered with the data so that the output follows the address
// by one cycle.
// Assumes: the writer never targets the same row of one bank twice in a cycle.
module eth_rx_bank_store #(
    parameter int ROW_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            wr_en,
    input  logic [1:0][ROW_W-1:0] wr_row,
    input  logic [1:0][31:0]      wr_data,
    input  logic [ROW_W-1:0]      rd_row,
    input  logic                  rd_bank,
    output logic [31:0]           rd_data
);

    localparam int ROWS = 1 << ROW_W;

    logic [31:0] bank_rd [2];
    logic        rd_bank_q;

    for (genvar b = 0; b < 2; b++) begin : gen_bank
        logic [31:0] mem [ROWS];
        logic [31:0] rd_q;

        // Write the completed word and read the addressed row.
        always_ff @(posedge clk) begin
            if (wr_en[b]) mem[wr_row[b]] <= wr_data[b];
            rd_q <= mem[rd_row];
        end

        assign bank_rd[b] = rd_q;
    end

    // Remember which bank the pending read came from.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_bank_q <= 1'b0;
        else        rd_bank_q <= rd_bank;
    end

    always_comb rd_data = bank_rd[rd_bank_q];

endmodule

// File: rtl/eth_rx_buf_ctrl.sv
// Buffer ownership and interrupt control.
// Holds the full flag and interrupt enable of each buffer, the selected buffer
// and the interrupt pulse. A hardware completion sets the flag and wins over a
// software release in the same cycle; the interrupt uses the enable as held
// before any write in that cycle.
// Assumes: commit targets the currently selected buffer.
module eth_rx_buf_ctrl
    import eth_rx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        commit,
    input  logic        pingpong_en,
    input  logic        irq_global_en,
    input  logic        ctl_we,
    input  logic        ctl_buf,
    input  logic        ctl_wr_full,
    input  logic        ctl_wr_ien,
    input  logic        rd_buf,
    output logic        sel,
    output logic        sel_full,
    output logic        rx_ready,
    output logic        irq,
    output logic [31:0] ctl_rdata
);

    logic [1:0] full_q;
    logic [1:0] ien_q;

    // Update flags, enables, selection and the interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 2'b00;
            ien_q  <= 2'b00;
            sel    <= 1'b0;
            irq    <= 1'b0;
        end else begin
            for (int b = 0; b < 2; b++) begin
                if (ctl_we && (ctl_buf == 1'(b))) begin
                    ien_q[b] <= ctl_wr_ien;
                    if (!ctl_wr_full) full_q[b] <= 1'b0;
                end
                if (commit && (sel == 1'(b))) full_q[b] <= 1'b1;
            end
            if (commit) sel <= pingpong_en ? !sel : 1'b0;
            irq <= commit && ien_q[sel] && irq_global_en;
        end
    end

    // Status toward the frame sequencer and the stream source.
    always_comb begin
        sel_full = full_q[sel];
        rx_ready = !full_q[sel];
    end

    // Control word image for the buffer being read.
    always_comb begin
        ctl_rdata                = '0;
        ctl_rdata[CTRL_FULL_BIT] = full_q[rd_buf];
        ctl_rdata[CTRL_IEN_BIT]  = ien_q[rd_buf];
    end

    assert_full_after_commit0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !sel) |=> full_q[0]);

    assert_full_after_commit1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && sel) |=> full_q[1]);

    assert_irq_follows_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(commit) && $past(irq_global_en));

    assert_single_buffer_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !pingpong_en) |=> !sel);

endmodule

// File: rtl/eth_rx_pingpong.sv
// Receive ping-pong buffer with destination filter (top level).
// Connects the frame sequencer, the two-bank store and the buffer control,
// and decodes the word-addressed bus window: top address bit picks the buffer,
// the last word of each buffer is its control word, reads take one cycle.
// Assumes: BUF_WORDS is a power of two, at least 4.
module eth_rx_pingpong
    import eth_rx_pkg::*;
#(
    parameter int BUF_WORDS = 512,
    localparam int WORD_W   = $clog2(BUF_WORDS),
    localparam int ADDR_W   = WORD_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    output logic              rx_ready,
    input  logic [47:0]       station_addr,
    input  logic              pingpong_en,
    input  logic              irq_global_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              rx_lost
);

    localparam logic [WORD_W-1:0] CTRL_WORD = WORD_W'(BUF_WORDS - 1);

    logic [1:0]              wr_en;
    logic [1:0][WORD_W-1:0]  wr_row;
    logic [1:0][31:0]        wr_data;
    logic                    commit;
    logic                    busy;
    logic                    sel;
    logic                    sel_full;
    logic                    bus_buf;
    logic [WORD_W-1:0]       bus_word;
    logic                    is_ctrl;
    logic [31:0]             ctl_rdata;
    logic [31:0]             mem_rdata;
    logic                    is_ctrl_q;
    logic [31:0]             ctl_rdata_q;

    // Split the bus address into buffer and word.
    always_comb begin
        bus_buf  = bus_addr[ADDR_W-1];
        bus_word = bus_addr[WORD_W-1:0];
        is_ctrl  = (bus_word == CTRL_WORD);
    end

    eth_rx_frame #(
        .BUF_WORDS (BUF_WORDS)
    ) u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .rx_last      (rx_last),
        .station_addr (station_addr),
        .sel          (sel),
        .sel_full     (sel_full),
        .wr_en        (wr_en),
        .wr_row       (wr_row),
        .wr_data      (wr_data),
        .commit       (commit),
        .lost         (rx_lost),
        .busy         (busy)
    );

    eth_rx_bank_store #(
        .ROW_W (WORD_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_row  (wr_row),
        .wr_data (wr_data),
        .rd_row  ({bus_buf, bus_word[WORD_W-1:1]}),
        .rd_bank (bus_word[0]),
        .rd_data (mem_rdata)
    );

    eth_rx_buf_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .commit        (commit),
        .pingpong_en   (pingpong_en),
        .irq_global_en (irq_global_en),
        .ctl_we        (bus_we && is_ctrl),
        .ctl_buf       (bus_buf),
        .ctl_wr_full   (bus_wdata[CTRL_FULL_BIT]),
        .ctl_wr_ien    (bus_wdata[CTRL_IEN_BIT]),
        .rd_buf        (bus_buf),
        .sel           (sel),
        .sel_full      (sel_full),
        .rx_ready      (rx_ready),
        .irq           (irq),
        .ctl_rdata     (ctl_rdata)
    );

    // Register the control image alongside the memory read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_ctrl_q   <= 1'b0;
            ctl_rdata_q <= '0;
        end else begin
            is_ctrl_q   <= is_ctrl;
            ctl_rdata_q <= ctl_rdata;
        end
    end

    always_comb bus_rdata = is_ctrl_q ? ctl_rdata_q : mem_rdata;

    // Hardware never writes frame data into a buffer software still owns (R7).
    assert_no_write_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_en) |-> !sel_full);

    // Selection holds while a frame is being received (R8).
    assert_sel_stable_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !commit) |=> $stable(sel));

    // Interrupt and lost pulses are mutually exclusive (R6).
    assert_irq_lost_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq, rx_lost}));

endmodule

// File: tb/eth_rx_pingpong_bench.sv
// Self-checking bench for eth_rx_pingpong with an 8-word buffer (28 data bytes).
module eth_rx_pingpong_bench;

    localparam int BW     = 8;
    localparam int AW     = 4;
    localparam int DBYTES = 4 * (BW - 1);
    localparam int DWORDS = BW - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            rx_valid = 1'b0;
    logic [7:0]      rx_data = 8'h00;
    logic            rx_last = 1'b0;
    logic            rx_ready;
    logic [47:0]     station_addr = 48'h5E4D3C2B1A02;
    logic            pp = 1'b1;
    logic            gie = 1'b1;
    logic [AW-1:0]   bus_addr = '0;
    logic            bus_we = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            irq;
    logic            rx_lost;

    int checks = 0;
    int fails  = 0;

    logic [7:0]  frm [64];
    logic [31:0] m_mem [2][DWORDS];
    bit          m_val [2][DWORDS];
    bit          m_full [2];
    bit          m_ien [2];
    bit          m_sel;

    always #2 clk = ~clk;

    eth_rx_pingpong #(.BUF_WORDS(BW)) u_eth_rx_pingpong (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_valid      (rx_valid),
        .rx_data       (rx_data),
        .rx_last       (rx_last),
        .rx_ready      (rx_ready),
        .station_addr  (station_addr),
        .pingpong_en   (pp),
        .irq_global_en (gie),
        .bus_addr      (bus_addr),
        .bus_we        (bus_we),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .irq           (irq),
        .rx_lost       (rx_lost)
    );

    task automatic check(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    function automatic logic [AW-1:0] ctl_addr(input bit b);
        return {b, 3'b111};
    endfunction

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        @(negedge clk);
        v = bus_rdata;
    endtask

    // Compare control words and every stored data word against the model.
    task automatic verify_buffers(input string tag);
        logic [31:0] v;
        for (int b = 0; b < 2; b++) begin
            bus_read(ctl_addr(b[0]), v);
            check(v == {28'h0, m_ien[b], 2'b00, m_full[b]},
                  $sformatf("%s R9 control word buf%0d", tag, b), v,
                  {28'h0, m_ien[b], 2'b00, m_full[b]});
            for (int w = 0; w < DWORDS; w++) begin
                if (m_val[b][w]) begin
                    bus_read({b[0], 3'(w)}, v);
                    check(v == m_mem[b][w],
                          $sformatf("%s R10 data buf%0d word%0d", tag, b, w), v, m_mem[b][w]);
                end
            end
        end
    endtask

    // Send frm[0:len-1]; optionally release the target buffer on the last byte.
    task automatic run_frame(input int len, input string tag, input bit conc);
        int  irqs = 0;
        int  losts = 0;
        int  b;
        int  nb;
        bit  match;
        bit  exp_acc;
        bit  exp_lost;
        bit  exp_irq;
        logic [31:0] wv;
        b = m_sel;
        match = 1'b1;
        for (int j = 0; j < 6; j++) if (frm[j] != station_addr[8*j +: 8]) match = 1'b0;
        match    = match || frm[0][7];
        exp_lost = m_full[b];
        exp_acc  = !exp_lost && (len >= 6) && match;
        exp_irq  = exp_acc && m_ien[b] && gie;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            irqs += int'(irq); losts += int'(rx_lost);
            rx_valid = 1'b1; rx_data = frm[k]; rx_last = (k == len - 1);
            if (conc && (k == len - 1)) begin
                bus_we = 1'b1; bus_addr = ctl_addr(b[0]); bus_wdata = 32'h0;
            end
        end
        @(negedge clk);
        irqs += int'(irq); losts += int'(rx_lost);
        rx_valid = 1'b0; rx_last = 1'b0; bus_we = 1'b0;
        @(negedge clk);
        irqs += int'(irq); losts += int'(rx_lost);
        if (exp_acc) begin
            nb = (len < DBYTES) ? len : DBYTES;
            for (int w = 0; w < (nb + 3) / 4; w++) begin
                wv = '0;
                for (int j = 0; j < 4; j++)
                    if (4 * w + j < nb) wv[8*j +: 8] = frm[4 * w + j];
                m_mem[b][w] = wv;
                m_val[b][w] = 1'b1;
            end
            m_full[b] = 1'b1;
            m_sel = pp ? !m_sel : 1'b0;
        end
        if (conc) begin
            m_ien[b] = 1'b0;
            if (!exp_acc) m_full[b] = 1'b0;
        end
        check(irqs == int'(exp_irq), $sformatf("%s R6 irq pulses len=%0d", tag, len), irqs, exp_irq);
        check(losts == int'(exp_lost), $sformatf("%s R7 lost pulses len=%0d", tag, len), losts, exp_lost);
        verify_buffers(tag);
    endtask

    task automatic release_buf(input int b);
        bus_write(ctl_addr(b[0]), {28'h0, m_ien[b], 3'b000});
        m_full[b] = 1'b0;
    endtask

    task automatic load_station_frame(input int len);
        for (int k = 0; k < 64; k++)
            frm[k] = (k < 6) ? station_addr[8*k +: 8] : 8'((k * 7 + len * 13) & 8'hFF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        for (int b = 0; b < 2; b++) begin
            m_full[b] = 1'b0; m_ien[b] = 1'b0;
            for (int w = 0; w < DWORDS; w++) begin m_val[b][w] = 1'b0; m_mem[b][w] = '0; end
        end
        m_sel = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check(rx_ready == 1'b1, "R1 rx_ready after reset", rx_ready, 1);
        check(irq == 1'b0, "R1 irq after reset", irq, 0);
        check(rx_lost == 1'b0, "R1 rx_lost after reset", rx_lost, 0);
        verify_buffers("R1");

        // R9 enable loads; writing full bit 1 does not set the flag
        bus_write(ctl_addr(1'b0), 32'h9);
        bus_write(ctl_addr(1'b1), 32'h8);
        m_ien[0] = 1'b1; m_ien[1] = 1'b1;
        verify_buffers("R9");

        // R2 R4 R5 length sweep across the short-frame and capacity limits
        for (int len = 1; len <= DBYTES + 4; len++) begin
            load_station_frame(len);
            if (len < 6)            run_frame(len, "R4", 1'b0);
            else if (len > DBYTES)  run_frame(len, "R5", 1'b0);
            else                    run_frame(len, "R2", 1'b0);
            for (int b = 0; b < 2; b++) if (m_full[b]) release_buf(b);
        end

        // R3 group address accepted
        load_station_frame(10);
        frm[0] = 8'h83; frm[3] = 8'h00;
        run_frame(10, "R3", 1'b0);
        for (int b = 0; b < 2; b++) if (m_full[b]) release_buf(b);

        // R3 mismatch in each of the six address bytes is rejected
        for (int p = 0; p < 6; p++) begin
            load_station_frame(12 + p);
            frm[p] = frm[p] ^ 8'h10;
            run_frame(12 + p, "R3", 1'b0);
        end

        // R7 both buffers full: third frame dropped, ready low
        load_station_frame(9);  run_frame(9, "R7", 1'b0);
        load_station_frame(14); run_frame(14, "R7", 1'b0);
        @(negedge clk);
        check(rx_ready == 1'b0, "R7 rx_ready with selected buffer full", rx_ready, 0);
        load_station_frame(20); run_frame(20, "R7", 1'b0);
        release_buf(m_sel);
        @(negedge clk);
        check(rx_ready == 1'b1, "R7 rx_ready after release", rx_ready, 1);
        for (int b = 0; b < 2; b++) if (m_full[b]) release_buf(b);

        // R8 alternation off: always back to buffer 0, drop on full buffer 0
        pp = 1'b0;
        load_station_frame(7);  run_frame(7, "R8", 1'b0);
        for (int b = 0; b < 2; b++) if (m_full[b]) release_buf(b);
        load_station_frame(11); run_frame(11, "R8", 1'b0);
        load_station_frame(13); run_frame(13, "R8", 1'b0);
        for (int b = 0; b < 2; b++) if (m_full[b]) release_buf(b);
        pp = 1'b1;

        // R6 interrupt gates: global off, then buffer enable off
        gie = 1'b0;
        load_station_frame(8); run_frame(8, "R6", 1'b0);
        for (int b = 0; b < 2; b++) if (m_full[b]) release_buf(b);
        gie = 1'b1;
        bus_write(ctl_addr(m_sel), 32'h0); m_ien[m_sel] = 1'b0;
        load_station_frame(16); run_frame(16, "R6", 1'b0);
        for (int b = 0; b < 2; b++) if (m_full[b]) release_buf(b);
        bus_write(ctl_addr(1'b0), 32'h8); m_ien[0] = 1'b1;
        bus_write(ctl_addr(1'b1), 32'h8); m_ien[1] = 1'b1;

        // R9 completion and release of the same buffer in one cycle
        load_station_frame(18); run_frame(18, "R9", 1'b1);
        load_station_frame(23); run_frame(23, "R9", 1'b1);

        finish_run();
    end

endmodule